// File: doc/BRIEF.md
# Configurable Debug Breakpoint Unit

This block watches a processor's instruction-fetch address stream and its data-memory load/store stream. When a programmed condition is met, it raises a break request toward the debug logic. It has four address comparator slots. Slots 0 and 1 always compare fetch addresses. Slots 2 and 3 are combined slots: each can be set to compare fetch addresses or data addresses. The two of them can also be joined into a single masked fetch-address (range) match, where slot 2 holds the value and slot 3 holds the care mask. Two further sources exist: a break on any change of program flow, and a single-step break.

Software programs the unit through a small register write port. Register 0 is control, registers 1 to 4 hold the slot values, and register 5 is a write-one-to-clear port for the sticky cause flags. The cause flags are visible on an output bus. A debug controller uses the one-cycle break request to halt the core. It then reads the cause bus to learn why the core stopped.

Top module: `bkpt_unit`

## Requirements
- R1: Slots 0 and 1 each flag a hit (cause bits 0 and 1) when `fetch_valid` is high, the slot is enabled, and `fetch_addr` equals the slot value. They never compare data addresses.
- R2: Control bits 7 and 8 choose the address space of slot 2 and slot 3: 0 for fetch, 1 for data. A slot set to data ignores fetches, and a slot set to fetch ignores data accesses. Hits appear on cause bits 2 and 3.
- R3: A data-mode slot hits only when `dmem_valid` is high and `dmem_addr` matches. In addition, its read qualifier must be set for a read (`dmem_we`=0), or its write qualifier must be set for a write (`dmem_we`=1). The read qualifiers for slots 2 and 3 are control bits 10 and 11; the write qualifiers are bits 12 and 13.
- R4: When control bit 9 (range) is set, slots 2 and 3 give no single hits. Instead, cause bit 4 flags a valid fetch whose address equals the slot 2 value on every bit where the slot 3 value holds 1. This match is enabled by slot 2's enable bit.
- R5: Control bits 3 to 6 enable slots 0 to 3. A disabled slot never flags a hit.
- R6: When control bit 1 is set, a valid fetch with `fetch_flow_chg` high flags cause bit 5.
- R7: When control bit 2 is set, each `instr_retire` pulse flags cause bit 6.
- R8: When control bit 0 (unit enable) is clear, `brk_req` stays low and no cause bit is set.
- R9: `brk_req` rises on the clock edge after a cycle with any enabled hit. It is high for exactly that one cycle unless the next cycle also hits.
- R10: Cause bits are sticky. Writing 1 to a bit of register 5 clears that bit, and writing 0 leaves it unchanged. A hit in the same cycle as a clear of that bit leaves the bit set.
- R11: After reset, all configuration registers, `brk_cause` and `brk_req` are zero.
- R12: Fetch comparisons use only cycles where `fetch_valid` is high. Data comparisons use only cycles where `dmem_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 control, 1-4 slots, 5 cause clear) |
| cfg_wdata | input | ADDR_W | Register write data |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_flow_chg | input | 1 | Fetch is a branch, jump, call or return target |
| instr_retire | input | 1 | One instruction completed |
| dmem_valid | input | 1 | Load/store strobe |
| dmem_we | input | 1 | 1 for store, 0 for load |
| dmem_addr | input | ADDR_W | Data address |
| brk_req | output | 1 | Registered break request pulse |
| brk_cause | output | 7 | Sticky cause flags |

## Verification
The bench targets the mode boundaries. It checks that a combined slot set to data stays quiet on a matching fetch; a design that ignores the mode bit would break on the wrong bus. It drives a store to a read-only data slot, which catches swapped or missing access qualifiers. In range mode it fetches addresses inside and outside the masked window, and it checks that the single hits of slots 2 and 3 are suppressed. Finally, it clears a cause bit in the same cycle as a new hit on that bit, and checks that the bit stays set and that other sticky bits survive a partial clear. A design that let the clear win would lose a break cause.

// File: rtl/bkpt_pkg.sv
// Shared constants and types for the breakpoint unit.
// Assumes exactly four slots: two fetch-only, two combined.
package bkpt_pkg;
    localparam int NSLOT   = 4;
    localparam int NCAUSE  = 7;
    localparam int CFG_AW  = 3;

    // Control register bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_FLOW    = 1;
    localparam int CTL_STEP    = 2;
    localparam int CTL_SLOT_EN = 3;   // 4 bits
    localparam int CTL_MODE    = 7;   // 2 bits, slots 2..3
    localparam int CTL_RANGE   = 9;
    localparam int CTL_RD      = 10;  // 2 bits
    localparam int CTL_WR      = 12;  // 2 bits
    localparam int CTL_USED    = 14;

    // Register indices
    localparam logic [CFG_AW-1:0] REG_CTRL  = 3'd0;
    localparam logic [CFG_AW-1:0] REG_SLOT0 = 3'd1;
    localparam logic [CFG_AW-1:0] REG_CLR   = 3'd5;

    // Cause bit positions (0..3 are the slots)
    localparam int CAUSE_RANGE = 4;
    localparam int CAUSE_FLOW  = 5;
    localparam int CAUSE_STEP  = 6;

    typedef struct packed {
        logic       unit_en;
        logic       flow_en;
        logic       step_en;
        logic [3:0] slot_en;
        logic [1:0] is_data;
        logic       range_mode;
        logic [1:0] rd_en;
        logic [1:0] wr_en;
    } bkpt_cfg_t;
endpackage

// File: rtl/bkpt_cfg_regs.sv
// Configuration register file for the breakpoint unit.
// Holds control and slot values; decodes the cause-clear write.
// Assumes ADDR_W >= CTL_USED so control bits fit in one write word.
module bkpt_cfg_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output bkpt_cfg_t                      cfg,
    output logic [NSLOT-1:0][ADDR_W-1:0]   slot_val,
    output logic [NCAUSE-1:0]              clr_mask
);
    logic [CTL_USED-1:0] ctrl_q;
    logic                unused_wdata;

    // Control register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (cfg_we && cfg_addr == REG_CTRL)
            ctrl_q <= cfg_wdata[CTL_USED-1:0];
    end

    // One value register per slot
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_val[g] <= '0;
            else if (cfg_we && cfg_addr == REG_SLOT0 + CFG_AW'(g))
                slot_val[g] <= cfg_wdata;
        end
    end

    // Unpack control word into named fields
    always_comb begin
        cfg.unit_en    = ctrl_q[CTL_EN];
        cfg.flow_en    = ctrl_q[CTL_FLOW];
        cfg.step_en    = ctrl_q[CTL_STEP];
        cfg.slot_en    = ctrl_q[CTL_SLOT_EN +: 4];
        cfg.is_data    = ctrl_q[CTL_MODE +: 2];
        cfg.range_mode = ctrl_q[CTL_RANGE];
        cfg.rd_en      = ctrl_q[CTL_RD +: 2];
        cfg.wr_en      = ctrl_q[CTL_WR +: 2];
    end

    // Write-one-to-clear mask for the cause flags
    assign clr_mask = (cfg_we && cfg_addr == REG_CLR) ? cfg_wdata[NCAUSE-1:0] : '0;

    assign unused_wdata = ^cfg_wdata;

    initial begin
        if (ADDR_W < CTL_USED) $error("ADDR_W too small for control word");
    end
endmodule

// File: rtl/bkpt_match.sv
// Comparator array: computes per-cycle cause flags from the fetch
// and data streams and the current configuration. Pure logic apart
// from the clock used by its assertions.
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  bkpt_cfg_t                     cfg,
    input  logic [NSLOT-1:0][ADDR_W-1:0]  slot_val,
    input  logic                          fetch_valid,
    input  logic [ADDR_W-1:0]             fetch_addr,
    input  logic                          fetch_flow_chg,
    input  logic                          instr_retire,
    input  logic                          dmem_valid,
    input  logic                          dmem_we,
    input  logic [ADDR_W-1:0]             dmem_addr,
    output logic [NCAUSE-1:0]             cause
);
    logic [NSLOT-1:0] slot_hit;
    logic             range_hit;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        if (g < 2) begin : g_prog
            // Fetch-only comparator
            assign slot_hit[g] = cfg.slot_en[g] && fetch_valid
                                 && fetch_addr == slot_val[g];
        end else begin : g_comb
            logic data_ok;
            logic prog_ok;
            // Data comparator with read/write qualifiers
            assign data_ok = dmem_valid && dmem_addr == slot_val[g]
                             && (dmem_we ? cfg.wr_en[g-2] : cfg.rd_en[g-2]);
            // Fetch comparator
            assign prog_ok = fetch_valid && fetch_addr == slot_val[g];
            // Mode select; range mode removes single hits
            assign slot_hit[g] = cfg.slot_en[g] && !cfg.range_mode
                                 && (cfg.is_data[g-2] ? data_ok : prog_ok);
        end
    end

    // Masked fetch match using slot 2 as value and slot 3 as mask
    assign range_hit = cfg.range_mode && cfg.slot_en[2] && fetch_valid
                       && ((fetch_addr ^ slot_val[2]) & slot_val[3]) == '0;

    // Gather cause vector
    always_comb begin
        cause                = '0;
        cause[NSLOT-1:0]     = slot_hit;
        cause[CAUSE_RANGE]   = range_hit;
        cause[CAUSE_FLOW]    = cfg.flow_en && fetch_valid && fetch_flow_chg;
        cause[CAUSE_STEP]    = cfg.step_en && instr_retire;
    end

    p_fetch_hits_need_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cause[0] || cause[1] || cause[CAUSE_RANGE] || cause[CAUSE_FLOW]) |-> fetch_valid);

    p_data_slot_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause[2] && cfg.is_data[0]) |->
            (dmem_valid && (dmem_we ? cfg.wr_en[0] : cfg.rd_en[0])));

    p_range_excludes_singles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.range_mode |-> !(cause[2] || cause[3]));

    p_disabled_slot_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause[NSLOT-1:0] & ~cfg.slot_en) == 0);
endmodule

// File: rtl/bkpt_unit.sv
// Breakpoint unit top: config registers, comparator array, sticky
// cause flags and the registered break request pulse.
// Assumes a single clock domain shared with the CPU pipeline.
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 fetch_flow_chg,
    input  logic                 instr_retire,
    input  logic                 dmem_valid,
    input  logic                 dmem_we,
    input  logic [ADDR_W-1:0]    dmem_addr,
    output logic                 brk_req,
    output logic [NCAUSE-1:0]    brk_cause
);
    bkpt_cfg_t                     cfg;
    logic [NSLOT-1:0][ADDR_W-1:0]  slot_val;
    logic [NCAUSE-1:0]             clr_mask;
    logic [NCAUSE-1:0]             cause_raw;
    logic [NCAUSE-1:0]             cause_live;
    logic [NCAUSE-1:0]             status_q;
    logic                          req_q;

    bkpt_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .slot_val  (slot_val),
        .clr_mask  (clr_mask)
    );

    bkpt_match #(.ADDR_W(ADDR_W)) u_match (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg            (cfg),
        .slot_val       (slot_val),
        .fetch_valid    (fetch_valid),
        .fetch_addr     (fetch_addr),
        .fetch_flow_chg (fetch_flow_chg),
        .instr_retire   (instr_retire),
        .dmem_valid     (dmem_valid),
        .dmem_we        (dmem_we),
        .dmem_addr      (dmem_addr),
        .cause          (cause_raw)
    );

    // Global enable gates every source
    assign cause_live = cause_raw & {NCAUSE{cfg.unit_en}};

    // Sticky flags: new hits win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_mask) | cause_live;
    end

    // Registered break request, one cycle per hitting cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= |cause_live;
    end

    assign brk_req   = req_q;
    assign brk_cause = status_q;

    p_req_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> status_q != '0);

    p_disabled_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.unit_en |=> !req_q);

    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));
endmodule

// File: tb/sim_bkpt_unit.sv
// Self-checking bench: a vector table walked by one loop, then
// directed tests for reset, sticky flags and clear priority.
module sim_bkpt_unit;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_flow_chg = 1'b0;
    logic          instr_retire = 1'b0;
    logic          dmem_valid = 1'b0;
    logic          dmem_we = 1'b0;
    logic [AW-1:0] dmem_addr = '0;
    logic          brk_req;
    logic [6:0]    brk_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bkpt_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_flow_chg(fetch_flow_chg), .instr_retire(instr_retire),
        .dmem_valid(dmem_valid), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .brk_req(brk_req), .brk_cause(brk_cause)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] v2;
        logic [15:0] v3;
        logic        fv;
        logic [15:0] fa;
        logic        flow;
        logic        ret;
        logic        dv;
        logic        dwe;
        logic [15:0] da;
        logic        req;
        logic [6:0]  st;
    } vec_t;

    localparam int NV = 17;
    // ctrl: en0 flow1 step2 slot_en3-6 mode7-8 range9 rd10-11 wr12-13
    localparam vec_t VECS [NV] = '{
        '{16'h0079, 16'h0300, 16'h0400, 1'b1, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 7'h04}, // R1 all prog, slot2
        '{16'h0079, 16'h0300, 16'h0400, 1'b1, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 7'h08}, // R1 slot3
        '{16'h0079, 16'h0300, 16'h0400, 1'b1, 16'h0101, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 7'h00}, // R1 miss
        '{16'h2979, 16'h0300, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0400, 1'b1, 7'h08}, // R2 3P+1D read
        '{16'h2979, 16'h0300, 16'h0400, 1'b1, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 7'h00}, // R2 data slot ignores fetch
        '{16'h25F9, 16'h0300, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0300, 1'b0, 7'h00}, // R3 write to rd-only
        '{16'h25F9, 16'h0300, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0300, 1'b1, 7'h04}, // R3 read hit
        '{16'h25F9, 16'h0300, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0400, 1'b1, 7'h08}, // R3 write hit
        '{16'h0279, 16'h1230, 16'hFFF0, 1'b1, 16'h1237, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 7'h10}, // R4 in range
        '{16'h0279, 16'h1230, 16'hFFF0, 1'b1, 16'h1247, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 7'h00}, // R4 out
        '{16'h0279, 16'h1230, 16'hFFF0, 1'b1, 16'hFFF0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 7'h00}, // R4 mask word no single hit
        '{16'h0003, 16'h0300, 16'h0400, 1'b1, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 7'h20}, // R6 flow
        '{16'h0003, 16'h0300, 16'h0400, 1'b0, 16'h5555, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0300, 1'b0, 7'h00}, // R12 no strobe
        '{16'h0005, 16'h0300, 16'h0400, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 7'h40}, // R7 step
        '{16'h007E, 16'h0300, 16'h0400, 1'b1, 16'h0100, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 7'h00}, // R8 unit off
        '{16'h0071, 16'h0300, 16'h0400, 1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 7'h00}, // R5 slot0 off
        '{16'h007B, 16'h0300, 16'h0400, 1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 7'h21}  // R6 flow + slot0
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle_inputs();
        fetch_valid = 1'b0; fetch_flow_chg = 1'b0; instr_retire = 1'b0;
        dmem_valid = 1'b0; dmem_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset req", {15'd0, brk_req}, 16'd0);
        chk("R11 reset cause", {9'd0, brk_cause}, 16'd0);

        wr(3'd1, 16'h0100);
        wr(3'd2, 16'h0200);

        for (int i = 0; i < NV; i++) begin
            wr(3'd5, 16'h007F);
            wr(3'd0, VECS[i].ctrl);
            wr(3'd3, VECS[i].v2);
            wr(3'd4, VECS[i].v3);
            fetch_valid = VECS[i].fv; fetch_addr = VECS[i].fa;
            fetch_flow_chg = VECS[i].flow; instr_retire = VECS[i].ret;
            dmem_valid = VECS[i].dv; dmem_we = VECS[i].dwe; dmem_addr = VECS[i].da;
            @(negedge clk);
            idle_inputs();
            chk($sformatf("vec%0d req", i), {15'd0, brk_req}, {15'd0, VECS[i].req});
            chk($sformatf("vec%0d cause", i), {9'd0, brk_cause}, {9'd0, VECS[i].st});
            @(negedge clk);
            chk($sformatf("R9 vec%0d pulse ends", i), {15'd0, brk_req}, 16'd0);
        end

        // R10 sticky hold and partial clear
        wr(3'd5, 16'h007F);
        wr(3'd0, 16'h0079);
        wr(3'd3, 16'h0300);
        fetch_valid = 1'b1; fetch_addr = 16'h0100;
        @(negedge clk);
        fetch_addr = 16'h0200;
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        chk("R10 sticky", {9'd0, brk_cause}, 16'h0003);
        chk("R9 idle req low", {15'd0, brk_req}, 16'd0);
        wr(3'd5, 16'h0001);
        chk("R10 partial clear", {9'd0, brk_cause}, 16'h0002);

        // R10 set wins over same-cycle clear
        cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 16'h0002;
        fetch_valid = 1'b1; fetch_addr = 16'h0200;
        @(negedge clk);
        cfg_we = 1'b0; idle_inputs();
        chk("R10 set wins", {9'd0, brk_cause}, 16'h0002);
        chk("R9 req on hit", {15'd0, brk_req}, 16'd1);

        // R11 mid-run reset clears config and flags
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset clears cause", {9'd0, brk_cause}, 16'd0);
        fetch_valid = 1'b1; fetch_addr = 16'h0000;
        @(negedge clk);
        idle_inputs();
        chk("R11 config cleared", {15'd0, brk_req}, 16'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule